// File: doc/BRIEF.md
# Privileged Counter Read Unit

This block keeps a free-running 64-bit clock-cycle counter and a small bank of 40-bit event counters. Each event counter advances by one on every clock in which its increment pulse is high. A single read port lets a processor core fetch any of these counters, and every read passes an access rule that depends on the kind of read it is.

A request gives a read kind, a 32-bit index, the requester's two-bit privilege level (0 is the most privileged), a timestamp-lock bit and a user-counter-enable bit. One clock later the block presents a registered response: a valid pulse, a fault flag and the counter value split into a high and a low 32-bit word. A refused read returns zero data with the fault flag set. Counter writes and event selection are handled elsewhere.

Top module: `cnt_read_unit`

## Requirements
- R1: The cycle counter is 64 bits wide. Reset clears it to 0, and it increases by exactly one on every clock edge in which reset is low.
- R2: The response for a request sampled at clock edge k appears after edge k as rsp_valid=1 for exactly one cycle. A cycle without a request yields rsp_valid=0, and rsp_fault, rsp_hi and rsp_lo are all zero in every cycle where rsp_valid is 0.
- R3: A cycle read (req_kind=2'b10) succeeds when req_tsdis=0 or req_priv=0. On success it returns counter bits 63:32 on rsp_hi and bits 31:0 on rsp_lo, using the value the counter holds at the request edge. In all other cases the read faults.
- R4: An event read (req_kind=2'b01) succeeds only when the full 32-bit index is 0 or 1, and either req_evten=1 or req_priv=0. In all other cases it faults.
- R5: A successful event read puts counter bits 31:0 on rsp_lo and bits 39:32 on rsp_hi[7:0], with rsp_hi[31:8] zero.
- R6: Each of the two 40-bit event counters clears on reset and increases by one on each clock where its own bit of evt_inc is high. The two counters are independent of each other.
- R7: A model-register read (req_kind=2'b00) requires req_priv=0 and index CYC_IDX (default 32'h0000_0010). That read returns the cycle counter in the same split as R3 and ignores req_tsdis. Any other index, or any nonzero privilege level, faults.
- R8: Whenever rsp_fault is 1, rsp_hi and rsp_lo are zero. The kind code 2'b11 always faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_inc | input | 2 | Increment pulses, one per event counter |
| req_valid | input | 1 | Read request strobe |
| req_kind | input | 2 | 00 model register, 01 event counter, 10 cycle counter, 11 reserved |
| req_index | input | 32 | Counter or register index |
| req_priv | input | 2 | Requester privilege level, 0 most privileged |
| req_tsdis | input | 1 | Locks cycle reads to privilege 0 when set |
| req_evten | input | 1 | Opens event reads to every privilege level when set |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_fault | output | 1 | Read refused (protection fault) |
| rsp_hi | output | 32 | Upper data word |
| rsp_lo | output | 32 | Lower data word |

## Verification
A cycle counter that skips or stalls shows up on the next cycle read as a value that differs from the number of edges counted since reset. It is visible one clock after that read is issued. A wrong event count or a swapped counter select shows on the next event read, because the two counters are driven at different pulse rates. A wrong access decision is visible one clock after the request as a wrong fault flag together with non-zero or missing data.

// File: rtl/cru_pkg.sv
package cru_pkg;
  typedef enum logic [1:0] {
    RK_MODEL = 2'b00,
    RK_EVENT = 2'b01,
    RK_CYCLE = 2'b10,
    RK_RSVD  = 2'b11
  } rd_kind_e;
endpackage

// File: rtl/cru_cycle_ctr.sv
module cru_cycle_ctr #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst) count <= '0;
    else     count <= count + W'(1);
  end
endmodule

// File: rtl/cru_event_bank.sv
module cru_event_bank #(
  parameter int N = 2,
  parameter int W = 40
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [N-1:0]   inc,
  output logic [N*W-1:0] counts
);
  for (genvar g = 0; g < N; g++) begin : g_ctr
    logic [W-1:0] cnt_q;
    always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (inc[g]) cnt_q <= cnt_q + W'(1);
    end
    assign counts[g*W +: W] = cnt_q;
  end
endmodule

// File: rtl/cru_access_check.sv
module cru_access_check
  import cru_pkg::*;
#(
  parameter int                  CYC_W   = 64,
  parameter int                  EVT_W   = 40,
  parameter int                  NUM_EVT = 2,
  parameter int                  IDX_W   = 32,
  parameter int                  PRIV_W  = 2,
  parameter logic [IDX_W-1:0]    CYC_IDX = 32'h10
) (
  input  rd_kind_e                 kind,
  input  logic [IDX_W-1:0]         index,
  input  logic [PRIV_W-1:0]        priv,
  input  logic                     tsdis,
  input  logic                     evten,
  input  logic [CYC_W-1:0]         cyc,
  input  logic [NUM_EVT*EVT_W-1:0] evts,
  output logic                     fault,
  output logic [CYC_W-1:0]         data
);
  logic             top_priv;
  logic             evt_hit;
  logic [EVT_W-1:0] evt_sel;

  assign top_priv = (priv == '0);

  always_comb begin
    evt_hit = 1'b0;
    evt_sel = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (index == IDX_W'(i)) begin
        evt_hit = 1'b1;
        evt_sel = evts[i*EVT_W +: EVT_W];
      end
    end
  end

  always_comb begin
    fault = 1'b1;
    data  = '0;
    case (kind)
      RK_CYCLE: if (!tsdis || top_priv) begin
        fault = 1'b0;
        data  = cyc;
      end
      RK_EVENT: if (evt_hit && (evten || top_priv)) begin
        fault = 1'b0;
        data  = CYC_W'(evt_sel);
      end
      RK_MODEL: if (top_priv && index == CYC_IDX) begin
        fault = 1'b0;
        data  = cyc;
      end
      default: begin
        fault = 1'b1;
        data  = '0;
      end
    endcase
  end
endmodule

// File: rtl/cnt_read_unit.sv
module cnt_read_unit
  import cru_pkg::*;
#(
  parameter int               HALF_W  = 32,
  parameter int               EVT_W   = 40,
  parameter int               NUM_EVT = 2,
  parameter int               IDX_W   = 32,
  parameter int               PRIV_W  = 2,
  parameter logic [IDX_W-1:0] CYC_IDX = 32'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_EVT-1:0] evt_inc,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [IDX_W-1:0]  req_index,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic              req_tsdis,
  input  logic              req_evten,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [HALF_W-1:0] rsp_hi,
  output logic [HALF_W-1:0] rsp_lo
);
  localparam int CYC_W = 2 * HALF_W;

  logic [CYC_W-1:0]         cyc_q;
  logic [NUM_EVT*EVT_W-1:0] evt_flat;
  logic                     chk_fault;
  logic [CYC_W-1:0]         chk_data;

  cru_cycle_ctr #(.W(CYC_W)) u_cyc (
    .clk   (clk),
    .rst   (rst),
    .count (cyc_q)
  );

  cru_event_bank #(.N(NUM_EVT), .W(EVT_W)) u_evt (
    .clk    (clk),
    .rst    (rst),
    .inc    (evt_inc),
    .counts (evt_flat)
  );

  cru_access_check #(
    .CYC_W(CYC_W), .EVT_W(EVT_W), .NUM_EVT(NUM_EVT),
    .IDX_W(IDX_W), .PRIV_W(PRIV_W), .CYC_IDX(CYC_IDX)
  ) u_chk (
    .kind  (rd_kind_e'(req_kind)),
    .index (req_index),
    .priv  (req_priv),
    .tsdis (req_tsdis),
    .evten (req_evten),
    .cyc   (cyc_q),
    .evts  (evt_flat),
    .fault (chk_fault),
    .data  (chk_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_hi    <= '0;
      rsp_lo    <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_fault <= req_valid && chk_fault;
      if (req_valid && !chk_fault) begin
        rsp_hi <= chk_data[CYC_W-1:HALF_W];
        rsp_lo <= chk_data[HALF_W-1:0];
      end else begin
        rsp_hi <= '0;
        rsp_lo <= '0;
      end
    end
  end
endmodule

// File: rtl/cru_checker.sv
module cru_checker #(
  parameter int HALF_W = 32,
  parameter int PRIV_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [PRIV_W-1:0] req_priv,
  input logic              req_tsdis,
  input logic              rsp_valid,
  input logic              rsp_fault,
  input logic [HALF_W-1:0] rsp_hi,
  input logic [HALF_W-1:0] rsp_lo,
  input logic [2*HALF_W-1:0] cyc_q
);
  AST_CYC_STEP: assert property (@(posedge clk) disable iff (rst)
    !rst |=> cyc_q == $past(cyc_q) + (2*HALF_W)'(1)); // R1

  AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2

  AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid && !rsp_fault && rsp_hi == '0 && rsp_lo == '0); // R2

  AST_CYC_LOCKED: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_kind == 2'b10 && req_tsdis && req_priv != '0 |=> rsp_fault); // R3

  AST_EVT_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_kind == 2'b01 |=> rsp_hi[HALF_W-1:8] == '0); // R5

  AST_MODEL_PRIV: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_kind == 2'b00 && req_priv != '0 |=> rsp_fault); // R7

  AST_FAULT_ZERO: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> rsp_valid && rsp_hi == '0 && rsp_lo == '0); // R8

  AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (rst)
    req_valid && req_kind == 2'b11 |=> rsp_fault); // R8
endmodule

bind cnt_read_unit cru_checker #(.HALF_W(HALF_W), .PRIV_W(PRIV_W)) u_cru_checker (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_kind  (req_kind),
  .req_priv  (req_priv),
  .req_tsdis (req_tsdis),
  .rsp_valid (rsp_valid),
  .rsp_fault (rsp_fault),
  .rsp_hi    (rsp_hi),
  .rsp_lo    (rsp_lo),
  .cyc_q     (cyc_q)
);

// File: tb/cnt_read_unit_test.sv
`timescale 1ns/1ps
module cnt_read_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  evt_inc = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_index = '0;
  logic [1:0]  req_priv = '0;
  logic        req_tsdis = 1'b0;
  logic        req_evten = 1'b0;
  logic        rsp_valid, rsp_fault;
  logic [31:0] rsp_hi, rsp_lo;

  int applied = 0;
  int misses  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  cnt_read_unit uut (
    .clk(clk), .rst(rst), .evt_inc(evt_inc),
    .req_valid(req_valid), .req_kind(req_kind), .req_index(req_index),
    .req_priv(req_priv), .req_tsdis(req_tsdis), .req_evten(req_evten),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_hi(rsp_hi), .rsp_lo(rsp_lo)
  );

  // Bench model of the counters, built from R1 and R6
  logic [63:0] m_cyc = '0;
  logic [39:0] m_e0 = '0, m_e1 = '0;
  logic [7:0]  pat = '0;
  always @(posedge clk) begin
    if (rst) begin
      m_cyc <= '0; m_e0 <= '0; m_e1 <= '0;
    end else begin
      m_cyc <= m_cyc + 64'd1;
      if (evt_inc[0]) m_e0 <= m_e0 + 40'd1;
      if (evt_inc[1]) m_e1 <= m_e1 + 40'd1;
    end
  end
  // Two different pulse rates so that a swapped select shows (R6)
  always @(negedge clk) begin
    pat     <= pat + 8'd1;
    evt_inc <= {pat[2:0] == 3'b101, pat[0]};
  end

  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] idx;
    logic [1:0]  priv;
    logic        tsdis;
    logic        evten;
    logic [1:0]  src;   // 0 cycle, 1 event0, 2 event1, 3 fault
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'b10, 32'h0,          2'd3, 1'b0, 1'b0, 2'd0, 4'd3}, // R3 open
    '{2'b10, 32'h0,          2'd0, 1'b1, 1'b0, 2'd0, 4'd3}, // R3 locked, priv 0
    '{2'b10, 32'h0,          2'd2, 1'b1, 1'b0, 2'd3, 4'd3}, // R3 locked fault
    '{2'b01, 32'h0,          2'd3, 1'b0, 1'b1, 2'd1, 4'd4}, // R4 enabled user
    '{2'b01, 32'h1,          2'd0, 1'b0, 1'b0, 2'd2, 4'd5}, // R5 priv 0
    '{2'b01, 32'h1,          2'd1, 1'b0, 1'b0, 2'd3, 4'd4}, // R4 disabled user
    '{2'b01, 32'h2,          2'd0, 1'b0, 1'b1, 2'd3, 4'd4}, // R4 bad index
    '{2'b01, 32'h0000_0100,  2'd0, 1'b0, 1'b1, 2'd3, 4'd4}, // R4 upper index bits
    '{2'b01, 32'h0,          2'd0, 1'b1, 1'b0, 2'd1, 4'd6}, // R6 event0
    '{2'b01, 32'h1,          2'd2, 1'b0, 1'b1, 2'd2, 4'd6}, // R6 event1
    '{2'b00, 32'h10,         2'd0, 1'b0, 1'b0, 2'd0, 4'd7}, // R7 mapped
    '{2'b00, 32'h10,         2'd0, 1'b1, 1'b0, 2'd0, 4'd7}, // R7 tsdis ignored
    '{2'b00, 32'h10,         2'd1, 1'b0, 1'b1, 2'd3, 4'd7}, // R7 priv fault
    '{2'b00, 32'h11,         2'd0, 1'b0, 1'b0, 2'd3, 4'd7}, // R7 unmapped
    '{2'b11, 32'h0,          2'd0, 1'b0, 1'b1, 2'd3, 4'd8}, // R8 reserved kind
    '{2'b10, 32'h0,          2'd1, 1'b0, 1'b0, 2'd0, 4'd1}  // R1 later cycle read
  };

  task automatic check(input string tag, input logic [65:0] got, input logic [65:0] exp);
    applied++;
    if (got !== exp) begin
      misses++;
      $display("FAIL %s: got v/f/hi/lo=%h expected %h", tag, got, exp);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge (R2 timing)
  task automatic run(input vec_t v, input string tag);
    logic [63:0] d;
    logic        f;
    req_valid = 1'b1; req_kind = v.kind; req_index = v.idx;
    req_priv = v.priv; req_tsdis = v.tsdis; req_evten = v.evten;
    f = (v.src == 2'd3);
    case (v.src)
      2'd0:    d = m_cyc;
      2'd1:    d = {24'h0, m_e0};
      2'd2:    d = {24'h0, m_e1};
      default: d = '0;
    endcase
    @(negedge clk);
    check(tag, {rsp_valid, rsp_fault, rsp_hi, rsp_lo}, {1'b1, f, d});
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset state", {rsp_valid, rsp_fault, rsp_hi, rsp_lo}, 66'h0);
    // Release reset and read at once: counter holds 0 at that edge (R1)
    rst = 1'b0;
    run('{2'b10, 32'h0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1}, "R1 first count");
    check("R1 zero after reset", {rsp_hi, rsp_lo}, 66'h0);
    @(negedge clk);
    check("R2 idle cycle", {rsp_valid, rsp_fault, rsp_hi, rsp_lo}, 66'h0);
    repeat (40) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      run(VECS[i], $sformatf("R%0d vector %0d", VECS[i].rq, i));
      repeat (i % 3) @(negedge clk);
    end
    @(negedge clk);
    check("R2 no request", {rsp_valid, rsp_fault, rsp_hi, rsp_lo}, 66'h0);
    // Mid-run reset clears the counters again (R1, R6)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    run('{2'b01, 32'h0, 2'd0, 1'b0, 1'b0, 2'd1, 4'd6}, "R6 after reset");
    check("R6 event0 zero", {rsp_hi, rsp_lo}, 66'h0);
    run('{2'b10, 32'h0, 2'd0, 1'b0, 1'b0, 2'd0, 4'd1}, "R1 after reset");
    check("R1 one edge since reset", {rsp_hi, rsp_lo}, 66'd1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      applied++;
      misses++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", applied, misses);
      $finish;
    end
  end
endmodule